// File: doc/BRIEF.md
# Calibrated Junction Temperature Converter

This block turns raw 12-bit readings from an on-die thermal sensor into a signed junction temperature in millidegrees Celsius. Codes arrive on a valid/ready stream. The block collects a burst of eight codes and averages them. It then divides out the sensor's curvature, maps the corrected value linearly between two calibration points, and rounds the result up to the next multiple of 500 m°C.

The two calibration points come from 32-bit trim words. Each trim word carries a valid flag. When a flag is clear, a built-in default is used in place of that word. The corrected value and the calibration slope each need an integer quotient. A single iterative divider produces both, one after the other. A conversion therefore takes a fixed number of cycles. The block accepts no new codes during that time.

Top module: `temp_conv`

## Requirements
- R1: During and right after a synchronous reset, `code_ready_o` is 1, `temp_done_o` is 0, `temp_mc_o` is 0 and `cal_err_o` is 0.
- R2: A code is taken only on a clock where both `code_valid_i` and `code_ready_o` are 1. After the eighth code of a burst is taken, `code_ready_o` stays 0 until the clock on which the result is delivered. Codes offered while it is 0 are ignored and do not count towards any burst.
- R3: The average is the sum of the eight taken codes divided by 8, with the remainder dropped.
- R4: The corrected value is avg·1000000 / (1000000 + 13·avg), using unsigned integer division.
- R5: The unrounded temperature is (corrected − lo)·q − 40000, where q = 165000 / (hi − lo) is an integer quotient.
- R6: The delivered temperature is the unrounded temperature rounded toward positive infinity to a multiple of 500. This includes values below zero.
- R7: When bit 31 of a trim word is 1, its calibration value is bits 11:0 of that word. All other bits are ignored. `trim_hi_i` supplies hi and `trim_lo_i` supplies lo. Both words are sampled on the clock that takes the eighth code.
- R8: When bit 31 of a trim word is 0, the default is used: hi = 3148 or lo = 503.
- R9: If hi ≤ lo, the delivered result has `cal_err_o` = 1 and `temp_mc_o` = 0. Otherwise `cal_err_o` is 0.
- R10: `temp_done_o` is a one-clock pulse. It rises 70 clocks after the clock that takes the eighth code. `temp_mc_o` and `cal_err_o` change only on that clock and then hold until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid_i | input | 1 | A sensor code is offered |
| code_ready_o | output | 1 | The block is collecting codes |
| code_i | input | 12 | Raw sensor code |
| trim_hi_i | input | 32 | Upper calibration trim word (bit 31 valid, bits 11:0 value) |
| trim_lo_i | input | 32 | Lower calibration trim word (bit 31 valid, bits 11:0 value) |
| temp_mc_o | output | 32 | Signed temperature in m°C |
| temp_done_o | output | 1 | One-clock pulse when a new result is delivered |
| cal_err_o | output | 1 | Calibration points are unusable (hi ≤ lo) |

## Verification
Every result is due exactly 70 clocks after the clock that takes the eighth code. That count is two 32-step divisions plus six control clocks. Ready must stay low for the whole of that window. The bench model counts down from 70 at that same edge. It compares ready, done, temperature and the error flag with the design on every falling edge, so an early or late pulse is caught as well as a wrong value. The stimulus includes codes held valid while ready is low, gaps between codes, trims with junk upper bits, negative temperatures and equal or inverted calibration points.

// File: rtl/temp_conv_pkg.sv
package temp_conv_pkg;

    localparam int CODE_W      = 12;
    localparam int BURST       = 8;
    localparam int DIV_W       = 32;
    localparam int SCALE       = 1000000;
    localparam int CURV_PPM    = 13;
    localparam int SPAN_MC     = 165000;
    localparam int OFFSET_MC   = 40000;
    localparam int GRAN_MC     = 500;
    localparam int DEF_HI      = 3148;
    localparam int DEF_LO      = 503;
    localparam int TRIM_VLD    = 31;

    localparam int CNT_W = $clog2(BURST);
    localparam int SUM_W = CODE_W + CNT_W;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_CORR_GO,
        ST_CORR_WAIT,
        ST_CAL_GO,
        ST_CAL_WAIT,
        ST_SCALE,
        ST_ROUND
    } conv_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
        logic              bad;
    } cal_pair_t;

    function automatic logic [CODE_W-1:0] trim_pick(input logic [31:0] word,
                                                    input int dflt);
        if (word[TRIM_VLD])
            return word[CODE_W-1:0];
        else
            return CODE_W'(dflt);
    endfunction

    function automatic cal_pair_t cal_build(input logic [31:0] hi_word,
                                            input logic [31:0] lo_word);
        cal_pair_t c;
        c.hi  = trim_pick(hi_word, DEF_HI);
        c.lo  = trim_pick(lo_word, DEF_LO);
        c.bad = (c.hi <= c.lo);
        return c;
    endfunction

endpackage

// File: rtl/temp_accum.sv
module temp_accum
    import temp_conv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              full_o,
    output logic [CODE_W-1:0] avg_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] hold_q;
    logic [SUM_W-1:0] acc_next;

    assign acc_next = acc_q + SUM_W'(code_i);
    assign full_o   = take_i && (cnt_q == CNT_W'(BURST - 1));
    assign avg_o    = hold_q[SUM_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            hold_q <= '0;
        end else if (take_i) begin
            if (full_o) begin
                cnt_q  <= '0;
                acc_q  <= '0;
                hold_q <= acc_next;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                acc_q <= acc_next;
            end
        end
    end

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        full_o |=> (cnt_q == '0 && acc_q == '0));

endmodule

// File: rtl/temp_divider.sv
module temp_divider
    import temp_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DIV_W-1:0] dividend_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DIV_W-1:0] quot_o
);

    localparam int STEP_W = $clog2(DIV_W + 1);

    logic [DIV_W:0]    rem_q;
    logic [DIV_W-1:0]  quo_q;
    logic [DIV_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic [DIV_W:0]    rem_sh;
    logic              fits;

    assign rem_sh = {rem_q[DIV_W-1:0], quo_q[DIV_W-1]};
    assign fits   = (rem_sh >= {1'b0, den_q});
    assign quot_o = quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_o) begin
                rem_q  <= '0;
                quo_q  <= dividend_i;
                den_q  <= divisor_i;
                step_q <= STEP_W'(DIV_W);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem_q  <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
                quo_q  <= {quo_q[DIV_W-2:0], fits};
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_o);

    // R5
    done_once_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/temp_conv.sv
module temp_conv
    import temp_conv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     code_valid_i,
    output logic                     code_ready_o,
    input  logic [CODE_W-1:0]        code_i,
    input  logic [31:0]              trim_hi_i,
    input  logic [31:0]              trim_lo_i,
    output logic signed [31:0]       temp_mc_o,
    output logic                     temp_done_o,
    output logic                     cal_err_o
);

    conv_state_e       state_q;
    cal_pair_t         cal_q;
    logic [CODE_W-1:0] corr_q;
    logic [DIV_W-1:0]  slope_q;
    logic signed [31:0] raw_q;

    logic              take;
    logic              burst_full;
    logic [CODE_W-1:0] avg;

    logic              div_start;
    logic [DIV_W-1:0]  div_num;
    logic [DIV_W-1:0]  div_den;
    logic              div_busy;
    logic              div_done;
    logic [DIV_W-1:0]  div_quot;

    logic signed [31:0] delta;
    logic signed [31:0] rem_c;
    logic signed [31:0] rounded;

    assign code_ready_o = (state_q == ST_COLLECT);
    assign take         = code_valid_i && code_ready_o;

    temp_accum u_accum (
        .clk    (clk),
        .rst    (rst),
        .take_i (take),
        .code_i (code_i),
        .full_o (burst_full),
        .avg_o  (avg)
    );

    always_comb begin
        div_start = 1'b0;
        div_num   = DIV_W'(SPAN_MC);
        div_den   = DIV_W'(cal_q.hi - cal_q.lo);
        if (state_q == ST_CORR_GO) begin
            div_start = 1'b1;
            div_num   = DIV_W'(avg) * DIV_W'(SCALE);
            div_den   = DIV_W'(SCALE) + DIV_W'(avg) * DIV_W'(CURV_PPM);
        end else if (state_q == ST_CAL_GO) begin
            div_start = 1'b1;
        end
    end

    temp_divider u_div (
        .clk        (clk),
        .rst        (rst),
        .start_i    (div_start),
        .dividend_i (div_num),
        .divisor_i  (div_den),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .quot_o     (div_quot)
    );

    assign delta   = $signed(32'(corr_q)) - $signed(32'(cal_q.lo));
    assign rem_c   = raw_q % GRAN_MC;
    assign rounded = (rem_c > 0) ? (raw_q + GRAN_MC - rem_c) : (raw_q - rem_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_COLLECT;
            cal_q       <= '0;
            corr_q      <= '0;
            slope_q     <= '0;
            raw_q       <= '0;
            temp_mc_o   <= '0;
            temp_done_o <= 1'b0;
            cal_err_o   <= 1'b0;
        end else begin
            temp_done_o <= 1'b0;
            unique case (state_q)
                ST_COLLECT: begin
                    if (burst_full) begin
                        cal_q   <= cal_build(trim_hi_i, trim_lo_i);
                        state_q <= ST_CORR_GO;
                    end
                end
                ST_CORR_GO:   state_q <= ST_CORR_WAIT;
                ST_CORR_WAIT: begin
                    if (div_done) begin
                        corr_q  <= div_quot[CODE_W-1:0];
                        state_q <= ST_CAL_GO;
                    end
                end
                ST_CAL_GO:    state_q <= ST_CAL_WAIT;
                ST_CAL_WAIT: begin
                    if (div_done) begin
                        slope_q <= div_quot;
                        state_q <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    raw_q   <= delta * $signed(slope_q) - OFFSET_MC;
                    state_q <= ST_ROUND;
                end
                ST_ROUND: begin
                    temp_mc_o   <= cal_q.bad ? 32'sd0 : rounded;
                    cal_err_o   <= cal_q.bad;
                    temp_done_o <= 1'b1;
                    state_q     <= ST_COLLECT;
                end
                default: state_q <= ST_COLLECT;
            endcase
        end
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        burst_full |=> !code_ready_o);

    // R6
    grid_chk: assert property (@(posedge clk) disable iff (rst)
        (temp_mc_o % GRAN_MC) == 0);

    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cal_err_o |-> (temp_mc_o == 0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        temp_done_o |=> !temp_done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !temp_done_o |-> ($stable(temp_mc_o) && $stable(cal_err_o)));

endmodule

// File: tb/temp_conv_test.sv
module temp_conv_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 70;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c_valid = 1'b0;
    logic [11:0] c_code = '0;
    logic [31:0] t_hi = '0;
    logic [31:0] t_lo = '0;
    logic        ready;
    logic signed [31:0] temp;
    logic        done;
    logic        err;

    int checks = 0;
    int failures = 0;
    string tag = "R5";
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    temp_conv uut (
        .clk          (clk),
        .rst          (rst),
        .code_valid_i (c_valid),
        .code_ready_o (ready),
        .code_i       (c_code),
        .trim_hi_i    (t_hi),
        .trim_lo_i    (t_lo),
        .temp_mc_o    (temp),
        .temp_done_o  (done),
        .cal_err_o    (err)
    );

    // reference model, written from the requirements
    function automatic int pick(input logic [31:0] w, input int d);
        return w[31] ? int'(w[11:0]) : d;
    endfunction

    function automatic longint ref_temp(input longint sum, input logic [31:0] wh,
                                        input logic [31:0] wl, output bit bad);
        longint avg, corr, hi, lo, q, v, r;
        hi  = pick(wh, 3148);
        lo  = pick(wl, 503);
        bad = (hi <= lo);
        if (bad) return 0;
        avg  = sum / 8;
        corr = (avg * 1000000) / (1000000 + avg * 13);
        q    = 165000 / (hi - lo);
        v    = (corr - lo) * q - 40000;
        r    = v % 500;
        if (r > 0) v = v + 500 - r;
        else       v = v - r;
        return v;
    endfunction

    int     m_n;
    longint m_sum;
    int     m_busy;
    bit     m_done;
    longint m_res;
    bit     m_err;
    longint p_res;
    bit     p_err;

    always @(posedge clk) begin
        if (rst) begin
            m_n <= 0; m_sum <= 0; m_busy <= 0; m_done <= 0;
            m_res <= 0; m_err <= 0;
        end else begin
            m_done <= 0;
            if (m_busy == 0 && c_valid) begin
                if (m_n == 7) begin
                    bit b;
                    longint v;
                    v = ref_temp(m_sum + c_code, t_hi, t_lo, b);
                    p_res <= v;
                    p_err <= b;
                    m_n <= 0; m_sum <= 0; m_busy <= LAT;
                end else begin
                    m_n <= m_n + 1;
                    m_sum <= m_sum + c_code;
                end
            end
            if (m_busy != 0) begin
                m_busy <= m_busy - 1;
                if (m_busy == 1) begin
                    m_done <= 1;
                    m_res  <= p_res;
                    m_err  <= p_err;
                end
            end
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (ready !== (m_busy == 0)) begin
                failures++;
                $display("FAIL R2 ready actual=%0b expected=%0b", ready, (m_busy == 0));
            end
            checks++;
            if (done !== m_done) begin
                failures++;
                $display("FAIL R10 done actual=%0b expected=%0b", done, m_done);
            end
            checks++;
            if (longint'(temp) != m_res || err !== m_err) begin
                failures++;
                $display("FAIL %s temp/err actual=%0d/%0b expected=%0d/%0b",
                         tag, temp, err, m_res, m_err);
            end
        end
    end

    task automatic push(input logic [11:0] c);
        c_valid = 1'b1;
        c_code  = c;
        while (!ready) @(negedge clk);
        @(negedge clk);
        c_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic burst_const(input logic [11:0] c);
        for (int i = 0; i < 8; i++) push(c);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (ready !== 1'b1 || done !== 1'b0 || temp !== 32'sd0 || err !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%0b%0b%0d%0b expected=1000", ready, done, temp, err);
        end

        // R8 defaults, steady code
        tag = "R8";
        t_hi = 32'h0000_0FFF; t_lo = 32'h0000_0001;
        burst_const(12'd1500);

        // R3 R4 R5 varied codes with gaps, sum not a multiple of 8
        tag = "R3";
        t_hi = 32'h8000_0C00; t_lo = 32'h8000_0200;
        for (int i = 0; i < 8; i++) begin
            push(12'(1000 + 37 * i + (i % 3)));
            idle(i % 3);
        end
        wait_done();

        // R7 junk upper bits ignored when valid flag set
        tag = "R7";
        t_hi = 32'hFFFF_FB80; t_lo = 32'hC5A3_E1F4;
        burst_const(12'd2222);

        // R2 codes offered while ready is low are ignored
        tag = "R2";
        t_hi = 32'h0; t_lo = 32'h0;
        for (int i = 0; i < 8; i++) push(12'd2000);
        c_valid = 1'b1; c_code = 12'hFFF;
        idle(40);
        c_valid = 1'b0;
        wait_done();
        burst_const(12'd2000);

        // R6 negative temperatures round toward +inf
        tag = "R6";
        burst_const(12'd100);
        burst_const(12'd333);
        t_hi = 32'h8000_0BCD; t_lo = 32'h8000_0123;
        burst_const(12'd517);

        // R4 maximum codes
        tag = "R4";
        t_hi = 32'h0; t_lo = 32'h0;
        burst_const(12'hFFF);
        burst_const(12'd0);

        // R9 inverted and equal calibration points
        tag = "R9";
        t_hi = 32'h8000_0100; t_lo = 32'h8000_0200;
        burst_const(12'd1800);
        t_hi = 32'h8000_0300; t_lo = 32'h8000_0300;
        burst_const(12'd1800);
        t_hi = 32'h8000_0001; t_lo = 32'h0;
        burst_const(12'd1800);

        // R10 recovery and back-to-back bursts
        tag = "R10";
        t_hi = 32'h0; t_lo = 32'h0;
        burst_const(12'd3000);
        burst_const(12'd2500);
        idle(5);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule